// File: doc/BRIEF.md
# Anti-phase receive word clock generator

This block turns a recovered bit-rate clock into a pair of word-rate clocks that run in opposite phase. Each high phase of either clock marks one received 10-bit word, so consecutive words land on alternate clocks. A downstream register captures a word on the rising edge of the clock that owns it, and each clock period spans two words (one twentieth of the bit rate). Everything runs in the bit-clock domain: the clock-like outputs are registered levels, and a one-cycle strobe marks every word boundary.

A word aligner that finds the comma in the wrong place raises a realign request with the number of bit positions the boundary must move. The generator lengthens the phase in progress by that many bit times and never shortens any phase. A shift of a full word, or more, is the worst case and adds exactly one word time. The phase-select output tells the data path which clock owns the word in progress. After reset both clocks are low, and the first rising edge goes to clock B, which carries word 0.

Top module: `rx_word_clk_gen`

## Requirements
- R1: While reset is asserted, wclk_a_o, wclk_b_o, word_stb_o and phase_sel_o are all 0.
- R2: After reset is released, wclk_b_o is the first clock to rise, exactly WORD_BITS bit cycles later, and it carries word 0.
- R3: With no realign requests, every phase between consecutive word boundaries lasts WORD_BITS bit cycles. Once started, the two clocks are complementary, and each rising edge of one clock is a falling edge of the other.
- R4: word_stb_o is high for exactly one bit cycle, in the first cycle of every high phase of either clock, and at no other time.
- R5: phase_sel_o is 1 while wclk_b_o owns the current word and 0 while wclk_a_o owns it. Owners alternate B, A, B, A from word 0.
- R6: A realign request with shift_i = k, 1 <= k < WORD_BITS, makes the phase in progress exactly WORD_BITS + k bit cycles long. This holds when the request is sampled in any cycle of that phase, including its last cycle.
- R7: shift_i >= WORD_BITS stretches the phase in progress by exactly WORD_BITS bit cycles, which is the largest stretch.
- R8: A request with shift_i = 0 has no effect. A second nonzero request in the same phase is ignored, and the first one sets the stretch.
- R9: No high or low phase of either clock is shorter than WORD_BITS or longer than 2*WORD_BITS bit cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| realign_i | input | 1 | Realign request from the word aligner, sampled each bit cycle |
| shift_i | input | SHIFT_W | Boundary shift in bit positions; 0 means none, values at or above WORD_BITS are clamped |
| wclk_a_o | output | 1 | Word clock A; carries words 1, 3, ... |
| wclk_b_o | output | 1 | Word clock B; carries words 0, 2, ... |
| word_stb_o | output | 1 | One-cycle pulse at each word boundary |
| phase_sel_o | output | 1 | 1 when clock B owns the current word |

## Verification
A phase counter that misses its limit shows up at the very next word boundary as a phase of the wrong length. The stretch bookkeeping is the riskier part. A request that is lost, added twice or applied to the next phase instead of the current one changes the spacing of the strobe within one phase, at most 2*WORD_BITS bit cycles. A corrupted phase state breaks the B-first alternation or the complementary relation of the clocks at the next strobe. The scoreboard therefore compares each strobe interval with the length the stimulus implies, and the owner with the word parity. It also measures every high and low phase against the lower and upper bounds.

// File: rtl/rx_wclk_pkg.sv
package rx_wclk_pkg;
  typedef enum logic [1:0] {
    WPH_IDLE = 2'd0,
    WPH_B    = 2'd1,
    WPH_A    = 2'd2
  } wphase_e;
endpackage

// File: rtl/rx_wclk_seg_timer.sv
module rx_wclk_seg_timer #(
  parameter int WORD_BITS = 10,
  parameter int EXT_W     = 4,
  parameter int CNT_W     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             realign_i,
  input  logic [EXT_W-1:0] shift_i,
  output logic             done_o
);
  localparam logic [EXT_W-1:0] EXT_MAX = EXT_W'(WORD_BITS);
  localparam logic [CNT_W-1:0] BASE_LAST = CNT_W'(WORD_BITS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] ext_q, ext_new, ext_eff;
  logic             taken_q, req;

  // clamp: one full word is the largest stretch
  assign ext_new = (shift_i > EXT_MAX) ? EXT_MAX : shift_i;
  // first nonzero request of the phase wins
  assign req     = realign_i && (shift_i != '0) && !taken_q;
  assign ext_eff = req ? ext_new : ext_q;
  assign done_o  = (cnt_q == BASE_LAST + CNT_W'(ext_eff));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ext_q   <= '0;
      taken_q <= 1'b0;
    end else if (done_o) begin
      cnt_q   <= '0;
      ext_q   <= '0;
      taken_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (req) begin
        ext_q   <= ext_new;
        taken_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_wclk_phase_gen.sv
module rx_wclk_phase_gen
  import rx_wclk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  output logic wclk_a_o,
  output logic wclk_b_o,
  output logic word_stb_o,
  output logic phase_sel_o
);
  wphase_e state_q, state_d;
  logic    stb_q;

  always_comb begin
    state_d = state_q;
    if (done_i) begin
      unique case (state_q)
        WPH_IDLE: state_d = WPH_B;
        WPH_B:    state_d = WPH_A;
        WPH_A:    state_d = WPH_B;
        default:  state_d = WPH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WPH_IDLE;
      stb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      stb_q   <= done_i;
    end
  end

  assign wclk_b_o    = (state_q == WPH_B);
  assign wclk_a_o    = (state_q == WPH_A);
  assign word_stb_o  = stb_q;
  assign phase_sel_o = (state_q == WPH_B);
endmodule

// File: rtl/rx_word_clk_gen.sv
module rx_word_clk_gen #(
  parameter int WORD_BITS = 10,
  parameter int SHIFT_W   = $clog2(WORD_BITS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               realign_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               wclk_a_o,
  output logic               wclk_b_o,
  output logic               word_stb_o,
  output logic               phase_sel_o
);
  localparam int CNT_W = $clog2(2 * WORD_BITS);

  logic seg_done;

  rx_wclk_seg_timer #(
    .WORD_BITS(WORD_BITS),
    .EXT_W    (SHIFT_W),
    .CNT_W    (CNT_W)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .realign_i(realign_i),
    .shift_i  (shift_i),
    .done_o   (seg_done)
  );

  rx_wclk_phase_gen u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (seg_done),
    .wclk_a_o   (wclk_a_o),
    .wclk_b_o   (wclk_b_o),
    .word_stb_o (word_stb_o),
    .phase_sel_o(phase_sel_o)
  );
endmodule

// File: rtl/rx_word_clk_chk.sv
module rx_word_clk_chk #(
  parameter int WORD_BITS = 10
) (
  input logic clk_i,
  input logic rst_ni,
  input logic wclk_a_i,
  input logic wclk_b_i,
  input logic word_stb_i,
  input logic phase_sel_i
);
  localparam int RUN_W = $clog2(2 * WORD_BITS + 2);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(2 * WORD_BITS + 1);

  logic             prev_b_q, seen_q, chg;
  logic [RUN_W-1:0] run_q;

  assign chg = (wclk_b_i != prev_b_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_b_q <= 1'b0;
      seen_q   <= 1'b0;
      run_q    <= '0;
    end else begin
      prev_b_q <= wclk_b_i;
      if (chg) begin
        run_q  <= RUN_W'(1);
        seen_q <= 1'b1;
      end else if (run_q != RUN_SAT) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  AST_ANTI_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wclk_a_i || wclk_b_i) |=> (wclk_a_i ^ wclk_b_i)); // R3
  AST_A_RISE_B_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wclk_a_i) |-> $fell(wclk_b_i)); // R3
  AST_STB_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_stb_i |-> ($rose(wclk_a_i) || $rose(wclk_b_i))); // R4
  AST_RISE_HAS_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(wclk_a_i) || $rose(wclk_b_i)) |-> word_stb_i); // R4
  AST_SEL_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_stb_i |-> (phase_sel_i == wclk_b_i)); // R5
  AST_MIN_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg && seen_q) |-> (run_q >= RUN_W'(WORD_BITS))); // R9
  AST_MAX_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_W'(2 * WORD_BITS)); // R7
endmodule

bind rx_word_clk_gen rx_word_clk_chk #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wclk_a_i   (wclk_a_o),
  .wclk_b_i   (wclk_b_o),
  .word_stb_i (word_stb_o),
  .phase_sel_i(phase_sel_o)
);

// File: tb/rx_word_clk_gen_tb.sv
module rx_word_clk_gen_tb;
  localparam int W  = 10;
  localparam int SW = $clog2(W + 1);

  typedef struct {
    int    len;
    string tag;
  } exp_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          realign_i = 1'b0;
  logic [SW-1:0] shift_i = '0;
  logic          wclk_a_o, wclk_b_o, word_stb_o, phase_sel_o;

  int   n_chk = 0, n_fail = 0;
  exp_t exp_q[$];
  bit   mon_on = 1'b0, started = 1'b0, done = 1'b0;
  int   cyc = 0, word_n = 0, run_a = 0, run_b = 0;
  logic prev_a = 1'b0, prev_b = 1'b0;

  always #2.5 clk_i = ~clk_i;

  rx_word_clk_gen #(.WORD_BITS(W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .realign_i(realign_i), .shift_i(shift_i),
    .wclk_a_o(wclk_a_o), .wclk_b_o(wclk_b_o), .word_stb_o(word_stb_o),
    .phase_sel_o(phase_sel_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int stretched(input int k);
    return W + ((k > W) ? W : k);
  endfunction

  // driver: one call per phase, pushes its expected length at phase start
  task automatic do_seg(input bit req, input int k1, input int d1,
                        input bit two, input int k2, input int d2, input string tag);
    exp_t e;
    do @(negedge clk_i); while (!word_stb_o);
    e.len = req ? stretched(k1) : W;
    e.tag = tag;
    exp_q.push_back(e);
    if (req) begin
      repeat (d1) @(negedge clk_i);
      realign_i = 1'b1; shift_i = SW'(k1);
      @(negedge clk_i);
      realign_i = 1'b0; shift_i = '0;
      if (two) begin
        repeat (d2 - d1 - 1) @(negedge clk_i);
        realign_i = 1'b1; shift_i = SW'(k2);
        @(negedge clk_i);
        realign_i = 1'b0; shift_i = '0;
      end
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (mon_on) begin
      cyc++;
      if (started) begin
        if (wclk_a_o != prev_a) begin
          check(run_a >= W && run_a <= 2 * W, "R9 clock A phase length", run_a, W);
          run_a = 1;
        end else run_a++;
        if (wclk_b_o != prev_b) begin
          check(run_b >= W && run_b <= 2 * W, "R9 clock B phase length", run_b, W);
          run_b = 1;
        end else run_b++;
      end
      if (word_stb_o) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected strobe", cyc, 0);
        end else begin
          e = exp_q.pop_front();
          check(cyc == e.len, e.tag, cyc, e.len);
        end
        if (word_n % 2 == 0)
          check(wclk_b_o && !wclk_a_o && phase_sel_o, "R5 owner B (word even)",
                {wclk_b_o, wclk_a_o, phase_sel_o}, 3'b101);
        else
          check(wclk_a_o && !wclk_b_o && !phase_sel_o, "R5 owner A (word odd)",
                {wclk_b_o, wclk_a_o, phase_sel_o}, 3'b010);
        if (!started) begin
          started = 1'b1; run_a = 1; run_b = 1;
        end
        word_n++;
        cyc = 0;
      end
      prev_a = wclk_a_o;
      prev_b = wclk_b_o;
    end
  end

  initial begin
    exp_t e0;
    repeat (3) @(negedge clk_i);
    check(!wclk_a_o && !wclk_b_o && !word_stb_o && !phase_sel_o, "R1 reset state",
          {wclk_a_o, wclk_b_o, word_stb_o, phase_sel_o}, 0);
    realign_i = 1'b1; shift_i = SW'(5);
    @(negedge clk_i);
    check(!wclk_a_o && !wclk_b_o && !word_stb_o, "R1 reset holds under request",
          {wclk_a_o, wclk_b_o, word_stb_o}, 0);
    realign_i = 1'b0; shift_i = '0;
    e0.len = W; e0.tag = "R2 first rise on clock B";
    exp_q.push_back(e0);
    #1 rst_ni = 1'b1; mon_on = 1'b1;
    do_seg(0, 0, 0, 0, 0, 0, "R3 plain phase 1");
    do_seg(0, 0, 0, 0, 0, 0, "R3 plain phase 2");
    do_seg(0, 0, 0, 0, 0, 0, "R3 plain phase 3");
    do_seg(1, 3, 0, 0, 0, 0, "R6 shift 3 at first cycle");
    do_seg(1, 1, W - 1, 0, 0, 0, "R6 shift 1 at last cycle");
    do_seg(1, 9, 5, 0, 0, 0, "R6 shift 9 mid phase");
    do_seg(0, 0, 0, 0, 0, 0, "R3 plain after stretch");
    do_seg(1, W, 2, 0, 0, 0, "R7 shift of a full word");
    do_seg(1, 15, 4, 0, 0, 0, "R7 oversize shift clamped");
    do_seg(1, 0, 3, 0, 0, 0, "R8 zero shift ignored");
    do_seg(1, 2, 1, 1, 7, 3, "R8 second request ignored");
    do_seg(0, 0, 0, 0, 0, 0, "R3 plain final");
    while (exp_q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
    check(word_n == 13, "R4 strobe count", word_n, 13);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", word_n, 13);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule